// File: doc/BRIEF.md
# Serial Flash Byte Transfer Sequencer

This block takes over the inner loop of reading a serial flash one byte at a time. Normally a processor would toggle pins in software for this. One register write launches a fixed burst. The block runs the flash serial clock for eight bit periods and shifts the flash data output into a capture register, most significant bit first. The captured byte can then be read back through the register window.

When the configuration clock line sits high at the moment of launch, the same burst also feeds an FPGA's serial configuration port. Each sampled bit is placed on the configuration data pin, and the configuration clock is pulsed once per bit. The FPGA image then streams straight from flash to device with no software in the bit path. Software still owns chip select and flash command setup, and must leave the flash in a read state before each launch.

Each serial clock half-period lasts `HALF_CNT` system clocks. A whole burst therefore takes `16*HALF_CNT` cycles.

Top module: `fbyte_seq`

## Requirements
- R1: After reset, `busy`, `flash_sck` and `cfg_din` are 0, and the captured byte read at address 0xF9 is 0x00.
- R2: A burst starts only on a `reg_wr` cycle with `reg_addr` = 0xFE, `reg_wdata` bit 6 = 1 and `win_en` = 1. `busy` is then 1 from the next cycle. A write with bit 6 clear, with another address, or with `win_en` = 0 starts nothing.
- R3: A burst holds `busy` high for exactly `16*HALF_CNT` cycles. It produces exactly eight `flash_sck` high pulses, each bit period being `HALF_CNT` cycles low followed by `HALF_CNT` cycles high.
- R4: `flash_so` is sampled on the cycle edge where `flash_sck` rises and shifted in most significant bit first. After the burst, the captured byte holds the eight sampled bits, the first one in bit 7.
- R5: If `cfg_cclk_idle` is 1 at launch, `cfg_cclk` is low during each high half of `flash_sck` and rises at the end of each bit period, giving eight rising edges. `cfg_din` carries the bit sampled in that period, so the byte seen on `cfg_din` at those rising edges equals the flash byte.
- R6: If `cfg_cclk_idle` is 0 at launch, `cfg_cclk` follows `cfg_cclk_idle` for the whole burst and `cfg_din` does not change.
- R7: While `busy` is 1, start writes are ignored. The running burst keeps its length and its captured byte.
- R8: `rd_data` returns the captured byte when `reg_addr` = 0xF9 and `win_en` = 1. It returns 0x00 otherwise.
- R9: Outside a burst, `flash_sck` is 0 and `cfg_cclk` equals `cfg_cclk_idle`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_en | input | 1 | Register window enabled |
| reg_addr | input | 8 | Register address for writes and reads |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data; bit 6 requests a burst |
| rd_data | output | BITS | Read data for the addressed register |
| busy | output | 1 | Burst in progress |
| flash_sck | output | 1 | Flash serial clock, idle low |
| flash_so | input | 1 | Flash serial data output |
| cfg_cclk_idle | input | 1 | Software level of the configuration clock line |
| cfg_cclk | output | 1 | Configuration clock driven to the FPGA |
| cfg_din | output | 1 | Configuration serial data to the FPGA |

## Verification
If the bit counter or phase bit goes wrong, the error shows within one burst, i.e. within `16*HALF_CNT` cycles. It appears as a `busy` window of the wrong length and a count other than eight on `flash_sck` and `cfg_cclk`. A shift fault or a wrong sample edge shows up as a wrong byte at 0xF9 right after `busy` falls. A wrong launch-time decision shows up as configuration clock edges that appear or go missing in the same burst.

The bench sweeps every byte value through the pass-through path. This exposes any stuck or swapped capture bit.

// File: rtl/fbseq_pkg.sv
package fbseq_pkg;
  localparam logic [7:0] ADDR_START = 8'hFE;
  localparam logic [7:0] ADDR_DATA  = 8'hF9;
  localparam int unsigned START_BIT = 6;

  function automatic int unsigned burst_cycles(input int unsigned half, input int unsigned bits);
    return 2 * half * bits;
  endfunction

  function automatic logic is_start(input logic wr, input logic win,
                                    input logic [7:0] addr, input logic [7:0] data);
    return wr && win && (addr == ADDR_START) && data[START_BIT];
  endfunction

  function automatic logic is_data_rd(input logic win, input logic [7:0] addr);
    return win && (addr == ADDR_DATA);
  endfunction
endpackage

// File: rtl/fbseq_timer.sv
module fbseq_timer #(
  parameter int unsigned HALF_CNT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = $clog2(HALF_CNT) + 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CNT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/fbseq_ctrl.sv
module fbseq_ctrl #(
  parameter int unsigned BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic tick,
  input  logic cfg_lvl,
  output logic busy,
  output logic ph,
  output logic pass,
  output logic start_acc,
  output logic samp_stb,
  output logic bit_end,
  output logic burst_done
);
  localparam int unsigned BW = $clog2(BITS) + 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

  logic [BW-1:0] bitn;

  assign start_acc  = start_req && !busy;
  assign samp_stb   = tick && !ph;
  assign bit_end    = tick && ph;
  assign burst_done = bit_end && (bitn == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= 1'b0;
      pass <= 1'b0;
      bitn <= '0;
    end else if (start_acc) begin
      busy <= 1'b1;
      ph   <= 1'b0;
      pass <= cfg_lvl;
      bitn <= '0;
    end else if (samp_stb) begin
      ph <= 1'b1;
    end else if (bit_end) begin
      ph <= 1'b0;
      if (burst_done) busy <= 1'b0;
      else bitn <= bitn + 1'b1;
    end
  end
endmodule

// File: rtl/fbseq_shift.sv
module fbseq_shift #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            samp_stb,
  input  logic            pass,
  input  logic            sdi,
  output logic [BITS-1:0] cap,
  output logic            cfg_din
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap     <= '0;
      cfg_din <= 1'b0;
    end else if (samp_stb) begin
      cap <= {cap[BITS-2:0], sdi};
      if (pass) cfg_din <= sdi;
    end
  end
endmodule

// File: rtl/fbyte_seq.sv
module fbyte_seq #(
  parameter int unsigned HALF_CNT = 2,
  parameter int unsigned BITS     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_en,
  input  logic [7:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [7:0]      reg_wdata,
  output logic [BITS-1:0] rd_data,
  output logic            busy,
  output logic            flash_sck,
  input  logic            flash_so,
  input  logic            cfg_cclk_idle,
  output logic            cfg_cclk,
  output logic            cfg_din
);
  import fbseq_pkg::*;

  logic start_req, start_acc, tick, samp_stb, bit_end, burst_done;
  logic ph, pass;
  logic [BITS-1:0] cap;

  assign start_req = is_start(reg_wr, win_en, reg_addr, reg_wdata);

  fbseq_timer #(.HALF_CNT(HALF_CNT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  fbseq_ctrl #(.BITS(BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .tick(tick),
    .cfg_lvl(cfg_cclk_idle), .busy(busy), .ph(ph), .pass(pass),
    .start_acc(start_acc), .samp_stb(samp_stb), .bit_end(bit_end),
    .burst_done(burst_done)
  );

  fbseq_shift #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .samp_stb(samp_stb), .pass(pass),
    .sdi(flash_so), .cap(cap), .cfg_din(cfg_din)
  );

  assign flash_sck = busy && ph;
  assign cfg_cclk  = (busy && pass) ? !ph : cfg_cclk_idle;
  assign rd_data   = is_data_rd(win_en, reg_addr) ? cap : '0;
endmodule

// File: rtl/fbyte_seq_chk.sv
module fbyte_seq_chk #(
  parameter int unsigned BITS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            win_en,
  input logic [7:0]      reg_addr,
  input logic [BITS-1:0] rd_data,
  input logic            busy,
  input logic            flash_sck,
  input logic            cfg_cclk_idle,
  input logic            cfg_cclk,
  input logic            start_acc,
  input logic            bit_end,
  input logic            burst_done
);
  localparam int unsigned RW = $clog2(BITS + 1) + 1;

  logic          lvl, sck_d;
  logic [RW-1:0] rises, ends;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= 1'b0; sck_d <= 1'b0; rises <= '0; ends <= '0;
    end else begin
      sck_d <= flash_sck;
      if (start_acc) begin
        lvl <= cfg_cclk_idle; rises <= '0; ends <= '0;
      end else begin
        if (flash_sck && !sck_d) rises <= rises + 1'b1;
        if (bit_end) ends <= ends + 1'b1;
      end
    end
  end

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy && !flash_sck);
  assert_eight_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rises == RW'(BITS));
  assert_done_on_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> ends == RW'(BITS - 1));
  assert_cfg_opposite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lvl) |-> cfg_cclk != flash_sck);
  assert_cfg_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lvl) |-> cfg_cclk == cfg_cclk_idle);
  assert_keep_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !burst_done) |=> busy);
  assert_rd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_en && reg_addr == 8'hF9) |-> rd_data == '0);
  assert_idle_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !flash_sck && cfg_cclk == cfg_cclk_idle);
endmodule

bind fbyte_seq fbyte_seq_chk #(.BITS(BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_en(win_en), .reg_addr(reg_addr),
  .rd_data(rd_data), .busy(busy), .flash_sck(flash_sck),
  .cfg_cclk_idle(cfg_cclk_idle), .cfg_cclk(cfg_cclk),
  .start_acc(start_acc), .bit_end(bit_end), .burst_done(burst_done)
);

// File: tb/fbyte_seq_tb.sv
module fbyte_seq_tb;
  localparam int unsigned HALF = 2;
  localparam int unsigned BLEN = HALF * 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_en = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] rd_data;
  logic busy, flash_sck, flash_so, cfg_cclk, cfg_din;
  logic cfg_cclk_idle = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] fl_byte = 8'h00;
  int fl_idx = 0;
  int fl_rise = 0;
  int cf_rise = 0;
  logic [7:0] cf_byte = 8'h00;

  always #4 clk = !clk;

  fbyte_seq #(.HALF_CNT(HALF), .BITS(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .rd_data(rd_data), .busy(busy),
    .flash_sck(flash_sck), .flash_so(flash_so), .cfg_cclk_idle(cfg_cclk_idle),
    .cfg_cclk(cfg_cclk), .cfg_din(cfg_din)
  );

  assign flash_so = (fl_idx < 8) ? fl_byte[3'(7 - fl_idx)] : 1'b0;
  always @(negedge flash_sck) fl_idx = fl_idx + 1;
  always @(posedge flash_sck) fl_rise = fl_rise + 1;
  always @(posedge cfg_cclk) begin
    cf_rise = cf_rise + 1;
    cf_byte = {cf_byte[6:0], cfg_din};
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, input logic w);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; win_en = w; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; win_en = 1'b1; reg_addr = 8'hF9;
  endtask

  task automatic read_cap(output int v);
    @(negedge clk);
    win_en = 1'b1; reg_addr = 8'hF9;
    #1 v = int'(rd_data);
  endtask

  // runs a burst; poke=1 issues another start write mid-burst (R7)
  task automatic burst(input logic [7:0] b, input logic lvl, input bit poke,
                       output int blen);
    @(negedge clk);
    cfg_cclk_idle = lvl;
    @(negedge clk);
    fl_byte = b; fl_idx = 0; fl_rise = 0; cf_rise = 0; cf_byte = 8'h00;
    wr_reg(8'hFE, 8'h40, 1'b1);
    blen = 0;
    while (busy && blen < 4 * BLEN) begin
      blen++;
      if (poke && blen == 5) begin
        reg_addr = 8'hFE; reg_wdata = 8'h40; reg_wr = 1'b1;
      end else begin
        reg_wr = 1'b0; reg_addr = 8'hF9;
      end
      if (!lvl) check("R6 cfg_cclk follows idle", int'(cfg_cclk), 0);
      @(negedge clk);
    end
    reg_wr = 1'b0; reg_addr = 8'hF9;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int v, blen;
    logic din_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 flash_sck", int'(flash_sck), 0);
    check("R1 cfg_din", int'(cfg_din), 0);
    read_cap(v); check("R1 capture", v, 0);

    // R2 non-start writes
    wr_reg(8'hFE, 8'hBF, 1'b1); #1 check("R2 bit6 clear", int'(busy), 0);
    wr_reg(8'hFD, 8'h40, 1'b1); #1 check("R2 other address", int'(busy), 0);
    wr_reg(8'hFE, 8'h40, 1'b0); #1 check("R2 window off", int'(busy), 0);
    repeat (BLEN) @(negedge clk);
    check("R2 no flash clocks", fl_rise, 0);
    check("R9 flash_sck idle", int'(flash_sck), 0);

    // pass-through sweep over every byte value
    for (int b = 0; b < 256; b++) begin
      burst(8'(b), 1'b1, 1'b0, blen);
      read_cap(v);
      check("R4 captured byte", v, b);
      check("R5 cfg byte", int'(cf_byte), b);
      check("R5 cfg rises", cf_rise, 8);
      check("R3 flash rises", fl_rise, 8);
      if (b % 32 == 0) check("R3 busy length", blen, BLEN);
    end
    check("R9 cfg idle high", int'(cfg_cclk), 1);

    // no pass-through: cfg lines untouched
    for (int b = 0; b < 256; b += 37) begin
      din_before = cfg_din;
      burst(8'(b ^ 8'h5A), 1'b0, 1'b0, blen);
      read_cap(v);
      check("R4 captured no-pass", v, b ^ 8'h5A);
      check("R6 cfg rises", cf_rise, 0);
      check("R6 cfg_din unchanged", int'(cfg_din), int'(din_before));
      check("R3 busy length no-pass", blen, BLEN);
    end

    // R7 start during busy ignored
    burst(8'hC3, 1'b1, 1'b1, blen);
    check("R7 busy length", blen, BLEN);
    read_cap(v); check("R7 captured", v, 8'hC3);
    check("R7 flash rises", fl_rise, 8);

    // R8 read gating
    @(negedge clk); win_en = 1'b0; reg_addr = 8'hF9;
    #1 check("R8 window off", int'(rd_data), 0);
    @(negedge clk); win_en = 1'b1; reg_addr = 8'hF8;
    #1 check("R8 other address", int'(rd_data), 0);
    @(negedge clk); reg_addr = 8'hF9;
    #1 check("R8 data address", int'(rd_data), 8'hC3);

    // R9 idle follow
    @(negedge clk); cfg_cclk_idle = 1'b0;
    #1 check("R9 cfg follows low", int'(cfg_cclk), 0);
    @(negedge clk); cfg_cclk_idle = 1'b1;
    #1 check("R9 cfg follows high", int'(cfg_cclk), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule